// File: doc/BRIEF.md
# I2C Slave Byte Receiver with Read-Paced Clock Hold

This block is the receive side of an I2C target. It samples the two bus lines against the system clock and detects start and stop conditions. It matches the first byte after every start against a programmable 7-bit address and acknowledges a match. Each following byte is moved into a buffer that the host reads. The bus lines are driven open-drain: the block only ever pulls a line low or lets it go.

With the hold option set, the block keeps the clock line low after every received byte until the host has read it. A fast master is therefore paced byte by byte by the host's read rate. A host-programmed acknowledge value lets software refuse the final byte of a transfer. Flags for bus busy, stop seen, interrupt, buffer full, read direction and a secondary receive event are visible through a small four-register host port.

Register map (host_addr):
- 0, control: bit 0 hold enable, bit 1 acknowledge value, bit 2 interrupt enable, bit 3 stop-interrupt mask, bit 4 secondary flag enable.
- 1, own address: bits 7:1 hold the address, and bit 0 reads 0.
- 2, status: bit 0 busy, bit 1 stop seen, bit 2 interrupt, bit 3 buffer full, bit 4 read direction, bit 5 secondary flag.
- 3, receive buffer.

Top module: `i2c_rx_stretch`

## Requirements
- R1: A start (SDA falls while SCL is high) sets busy (status bit 0). A stop (SDA rises while SCL is high) clears busy and sets stop seen (status bit 1).
- R2: When the address byte (7 address bits MSB first, then the direction bit) matches own address bits 7:1, SDA is pulled low in the 9th clock. If the direction bit is 1, the read-direction flag (status bit 4) is set; the next start clears it.
- R3: On an address mismatch the block leaves SDA released, sets no flag and ignores all bytes until the next start.
- R4: In the 9th clock of a data byte, SDA is pulled low when control bit 1 is 0 and left released when it is 1.
- R5: At the 9th rising SCL edge of every addressed frame the interrupt flag (status bit 2) is set, and irq_o equals that flag ANDed with control bit 2. For data frames the received byte (first bit received = bit 7) is copied into the buffer (address 3) and buffer full (status bit 3) is set.
- R6: With control bit 0 set, SCL is pulled low from the fall of the 9th clock of a data byte until the host reads address 3. That read clears buffer full and releases SCL.
- R7: A stop sets the interrupt flag only when control bit 3 is 0.
- R8: When control bit 4 is 1, each received data byte also sets the secondary flag (status bit 5).
- R9: A host write to address 2 clears each of status bits 1, 2 and 5 that is written as 0. A new event in the same cycle keeps the flag set.
- R10: A start seen in the middle of any byte abandons that byte; the next byte is treated as an address.
- R11: With control bit 0 clear, SCL is never pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_low_o | output | 1 | 1 pulls SCL low (clock hold) |
| sda_low_o | output | 1 | 1 pulls SDA low (acknowledge) |
| host_addr | input | 2 | Host register select |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle (side effect at address 3) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for host_addr |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with a three-stage line synchronizer and the default 8-bit byte width. The longer synchronizer lag still has to fit inside a bus half-phase of ten system clocks, so the ordering of the acknowledge drive, the release and the clock hold is exercised with realistic latency. The reset own address of 0x2A is checked, then overwritten at run time. Matched, mismatched and read-direction addresses can then all be mixed in random transfers with random hold, acknowledge, mask and enable settings.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
   typedef enum logic [1:0] {FR_IDLE, FR_ADDR, FR_DATA, FR_SKIP} fr_state_e;

   localparam logic [1:0] RA_CTRL = 2'd0;
   localparam logic [1:0] RA_OWN  = 2'd1;
   localparam logic [1:0] RA_STAT = 2'd2;
   localparam logic [1:0] RA_DATA = 2'd3;

   localparam int CB_HOLD  = 0;
   localparam int CB_ACK   = 1;
   localparam int CB_IRQEN = 2;
   localparam int CB_SMASK = 3;
   localparam int CB_ALTEN = 4;
   localparam int CTRL_W   = 5;

   localparam int SB_STOP = 1;
   localparam int SB_IRQ  = 2;
   localparam int SB_ALT  = 5;
endpackage

// File: rtl/i2c_rx_sync.sv
module i2c_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);
   localparam int LINES = 2;

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_rx_sync: STAGES must be at least 2");
   end

   logic [LINES-1:0] line_raw;
   logic [LINES-1:0] line_s;
   logic [LINES-1:0] line_prev;

   assign line_raw = {sda_in, scl_in};

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[STAGES-2:0], line_raw[g]};
      end
      assign line_s[g] = chain[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_prev <= '1;
      else        line_prev <= line_s;
   end

   assign sda_s     = line_s[1];
   assign scl_rise  = line_s[0] & ~line_prev[0];
   assign scl_fall  = ~line_s[0] & line_prev[0];
   assign start_evt = line_prev[1] & ~line_s[1] & line_s[0] & line_prev[0];
   assign stop_evt  = ~line_prev[1] & line_s[1] & line_s[0] & line_prev[0];
endmodule

// File: rtl/i2c_rx_frame.sv
module i2c_rx_frame
   import i2c_rx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_s,
   input  logic              start_evt,
   input  logic              stop_evt,
   input  logic [DATA_W-2:0] own_addr,
   input  logic              ack_val,
   output logic              sda_low,
   output logic [DATA_W-1:0] byte_q,
   output logic              addr_done,
   output logic              data_done,
   output logic              dir_rd,
   output logic              hold_req
);
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

   fr_state_e        st;
   logic [CNT_W-1:0] cnt;
   logic             ninth;
   logic             active;
   logic             ninth_rise;
   logic             addr_hit;

   assign active     = (st == FR_ADDR) || (st == FR_DATA);
   assign ninth_rise = active && scl_rise && (cnt == LAST) && !ninth;
   assign addr_done  = ninth_rise && (st == FR_ADDR);
   assign data_done  = ninth_rise && (st == FR_DATA);
   assign dir_rd     = byte_q[0];
   assign hold_req   = (st == FR_DATA) && scl_fall && ninth;
   assign addr_hit   = (byte_q[DATA_W-1:1] == own_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= FR_IDLE;
         cnt     <= '0;
         ninth   <= 1'b0;
         sda_low <= 1'b0;
         byte_q  <= '0;
      end else if (start_evt) begin
         st      <= FR_ADDR;
         cnt     <= '0;
         ninth   <= 1'b0;
         sda_low <= 1'b0;
      end else if (stop_evt) begin
         st      <= FR_IDLE;
         cnt     <= '0;
         ninth   <= 1'b0;
         sda_low <= 1'b0;
      end else if (active) begin
         if (scl_rise && cnt != LAST) begin
            byte_q <= {byte_q[DATA_W-2:0], sda_s};
            cnt    <= cnt + CNT_W'(1);
         end else if (ninth_rise) begin
            ninth <= 1'b1;
         end else if (scl_fall && cnt == LAST) begin
            if (ninth) begin
               sda_low <= 1'b0;
               cnt     <= '0;
               ninth   <= 1'b0;
               if (st == FR_ADDR) st <= byte_q[0] ? FR_SKIP : FR_DATA;
            end else if (st == FR_ADDR) begin
               if (addr_hit) sda_low <= 1'b1;
               else          st      <= FR_SKIP;
            end else begin
               sda_low <= ~ack_val;
            end
         end
      end
   end

   // R3
   skip_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FR_SKIP) |-> !sda_low);

   // R4
   ack_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sda_low |-> (cnt == LAST));
endmodule

// File: rtl/i2c_rx_regs.sv
module i2c_rx_regs
   import i2c_rx_pkg::*;
#(
   parameter int                DATA_W   = 8,
   parameter logic [DATA_W-2:0] OWN_RST  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        host_addr,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              start_evt,
   input  logic              stop_evt,
   input  logic              addr_done,
   input  logic              dir_rd,
   input  logic              data_done,
   input  logic [DATA_W-1:0] byte_in,
   input  logic              hold_req,
   output logic [DATA_W-2:0] own_addr,
   output logic              ack_val,
   output logic              scl_low,
   output logic              full,
   output logic              irq
);
   if (DATA_W < CTRL_W + 1) begin : g_bad_width
      $error("i2c_rx_regs: DATA_W too narrow for the status register");
   end

   logic [CTRL_W-1:0] ctrl_q;
   logic [DATA_W-2:0] own_q;
   logic [DATA_W-1:0] buf_q;
   logic busy_q, stop_q, irq_q, full_q, txdir_q, alt_q, stretch_q;
   logic wr_ctrl, wr_own, wr_stat, rd_data, irq_set, alt_set;

   assign wr_ctrl = host_wr && (host_addr == RA_CTRL);
   assign wr_own  = host_wr && (host_addr == RA_OWN);
   assign wr_stat = host_wr && (host_addr == RA_STAT);
   assign rd_data = host_rd && (host_addr == RA_DATA);
   assign irq_set = addr_done | data_done | (stop_evt & ~ctrl_q[CB_SMASK]);
   assign alt_set = data_done & ctrl_q[CB_ALTEN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         own_q     <= OWN_RST;
         buf_q     <= '0;
         busy_q    <= 1'b0;
         stop_q    <= 1'b0;
         irq_q     <= 1'b0;
         full_q    <= 1'b0;
         txdir_q   <= 1'b0;
         alt_q     <= 1'b0;
         stretch_q <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= host_wdata[CTRL_W-1:0];
         if (wr_own)  own_q  <= host_wdata[DATA_W-1:1];

         if (start_evt)     busy_q <= 1'b1;
         else if (stop_evt) busy_q <= 1'b0;

         if (stop_evt)                           stop_q <= 1'b1;
         else if (wr_stat && !host_wdata[SB_STOP]) stop_q <= 1'b0;

         if (irq_set)                            irq_q <= 1'b1;
         else if (wr_stat && !host_wdata[SB_IRQ]) irq_q <= 1'b0;

         if (alt_set)                            alt_q <= 1'b1;
         else if (wr_stat && !host_wdata[SB_ALT]) alt_q <= 1'b0;

         if (addr_done && dir_rd) txdir_q <= 1'b1;
         else if (start_evt)      txdir_q <= 1'b0;

         if (data_done) begin
            buf_q  <= byte_in;
            full_q <= 1'b1;
         end else if (rd_data) begin
            full_q <= 1'b0;
         end

         if (rd_data)                                       stretch_q <= 1'b0;
         else if (hold_req && ctrl_q[CB_HOLD] && full_q)    stretch_q <= 1'b1;
      end
   end

   always_comb begin
      unique case (host_addr)
         RA_CTRL: host_rdata = DATA_W'(ctrl_q);
         RA_OWN:  host_rdata = {own_q, 1'b0};
         RA_STAT: host_rdata = DATA_W'({alt_q, txdir_q, full_q, irq_q, stop_q, busy_q});
         default: host_rdata = buf_q;
      endcase
   end

   assign own_addr = own_q;
   assign ack_val  = ctrl_q[CB_ACK];
   assign scl_low  = stretch_q;
   assign full     = full_q;
   assign irq      = irq_q & ctrl_q[CB_IRQEN];

   // R1
   stop_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_evt && !start_evt) |=> (!busy_q && stop_q));

   // R2
   txdir_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_done && dir_rd) |=> txdir_q);

   // R5
   load_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_done |=> (full_q && irq_q));

   // R6
   read_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !data_done) |=> (!full_q && !stretch_q));

   // R7
   stop_masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_evt && ctrl_q[CB_SMASK] && !addr_done && !data_done && !irq_q) |=> !irq_q);

   // R9
   wr_clear_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && !host_wdata[SB_IRQ] && !addr_done && !data_done && !stop_evt) |=> !irq_q);

   // R11
   no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[CB_HOLD] && !stretch_q) |=> !stretch_q);
endmodule

// File: rtl/i2c_rx_stretch.sv
module i2c_rx_stretch #(
   parameter int              DATA_W       = 8,
   parameter int              SYNC_STAGES  = 2,
   parameter logic [DATA_W-2:0] OWN_ADDR_RST = 7'h2A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_low_o,
   output logic              sda_low_o,
   input  logic [1:0]        host_addr,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              irq_o
);
   logic              sda_s, scl_rise, scl_fall, start_evt, stop_evt;
   logic [DATA_W-2:0] own_addr;
   logic              ack_val, addr_done, data_done, dir_rd, hold_req, full_w;
   logic [DATA_W-1:0] byte_w;

   i2c_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_i), .sda_in(sda_i),
      .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_evt(start_evt), .stop_evt(stop_evt)
   );

   i2c_rx_frame #(.DATA_W(DATA_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_s(sda_s), .start_evt(start_evt), .stop_evt(stop_evt),
      .own_addr(own_addr), .ack_val(ack_val), .sda_low(sda_low_o),
      .byte_q(byte_w), .addr_done(addr_done), .data_done(data_done),
      .dir_rd(dir_rd), .hold_req(hold_req)
   );

   i2c_rx_regs #(.DATA_W(DATA_W), .OWN_RST(OWN_ADDR_RST)) u_regs (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .start_evt(start_evt), .stop_evt(stop_evt), .addr_done(addr_done),
      .dir_rd(dir_rd), .data_done(data_done), .byte_in(byte_w),
      .hold_req(hold_req), .own_addr(own_addr), .ack_val(ack_val),
      .scl_low(scl_low_o), .full(full_w), .irq(irq_o)
   );

   // R6
   hold_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scl_low_o |-> full_w);
endmodule

// File: tb/i2c_rx_stretch_test.sv
module i2c_rx_stretch_test;
   localparam int Q = 5;
   localparam logic [6:0] OWN = 7'h3C;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic scl_low_o, sda_low_o, irq_o;
   logic [1:0] haddr = 2'd0;
   logic hwr = 1'b0, hrd = 1'b0;
   logic [7:0] hwdata = 8'd0, hrdata;
   wire scl_line = scl_m & ~scl_low_o;
   wire sda_line = sda_m & ~sda_low_o;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   i2c_rx_stretch #(.DATA_W(8), .SYNC_STAGES(3), .OWN_ADDR_RST(7'h2A)) uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
      .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .host_addr(haddr),
      .host_wr(hwr), .host_rd(hrd), .host_wdata(hwdata), .host_rdata(hrdata),
      .irq_o(irq_o)
   );

   task automatic chk(input string r, input int a, input int e);
      checks++;
      if (a != e) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", r, a, e);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic peek(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); haddr = a; #1 d = hrdata;
   endtask

   task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); haddr = a; hwdata = d; hwr = 1'b1;
      @(negedge clk); hwr = 1'b0;
   endtask

   task automatic hread_buf(output logic [7:0] d);
      @(negedge clk); haddr = 2'd3; hrd = 1'b1; #1 d = hrdata;
      @(negedge clk); hrd = 1'b0;
   endtask

   function automatic int sbit(input logic [7:0] s, input int b);
      return int'(s[b]);
   endfunction

   function automatic logic [7:0] ctrl_word(input bit hold, input bit ackv,
                                            input bit ien, input bit smask, input bit alt);
      return {3'b000, alt, smask, ien, ackv, hold};
   endfunction

   function automatic int exp_ack(input bit is_addr, input bit hit, input bit ackv);
      if (is_addr) return hit ? 0 : 1;
      return ackv ? 1 : 0;
   endfunction

   task automatic bit_x(input logic b, output logic seen);
      wait_cyc(Q); sda_m = b; wait_cyc(Q);
      scl_m = 1'b1;
      while (!scl_line) @(negedge clk);
      wait_cyc(Q); seen = sda_line; wait_cyc(Q);
      scl_m = 1'b0;
   endtask

   task automatic start_c();
      wait_cyc(Q); sda_m = 1'b1; wait_cyc(Q);
      scl_m = 1'b1;
      while (!scl_line) @(negedge clk);
      wait_cyc(Q); sda_m = 1'b0; wait_cyc(Q);
      scl_m = 1'b0;
   endtask

   task automatic stop_c();
      wait_cyc(Q); sda_m = 1'b0; wait_cyc(Q);
      scl_m = 1'b1;
      while (!scl_line) @(negedge clk);
      wait_cyc(Q); sda_m = 1'b1; wait_cyc(2 * Q);
   endtask

   task automatic byte_x(input logic [7:0] v, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) bit_x(v[i], s);
      bit_x(1'b1, ack);
   endtask

   task automatic bits_x(input logic [7:0] v, input int n);
      logic s;
      for (int i = 7; i > 7 - n; i--) bit_x(v[i], s);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog (R1..R11 run hung): actual 0 expected 1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] s, d, v2;
      logic a;
      void'($urandom(32'd2024));
      wait_cyc(4);
      rst_n = 1'b1;
      wait_cyc(4);

      // reset state
      peek(2'd2, s); chk("R1 reset status", int'(s), 0);
      peek(2'd1, s); chk("R2 reset own address", int'(s), 8'h54);
      chk("R11 reset scl hold", int'(scl_low_o), 0);
      chk("R5 reset irq_o", int'(irq_o), 0);

      hwrite(2'd1, {OWN, 1'b0});
      hwrite(2'd0, ctrl_word(0, 0, 1, 0, 0));

      // R1 start sets busy, R2 address ack
      start_c();
      peek(2'd2, s); chk("R1 busy after start", sbit(s, 0), 1);
      byte_x({OWN, 1'b0}, a); chk("R2 address ack", int'(a), 0);
      peek(2'd2, s); chk("R5 irq on address", sbit(s, 2), 1);
      chk("R5 irq_o enabled", int'(irq_o), 1);
      hwrite(2'd2, 8'h00);
      peek(2'd2, s); chk("R9 irq cleared by write 0", sbit(s, 2), 0);

      // R10 repeated start inside a data byte
      bits_x(8'hF0, 4);
      start_c();
      peek(2'd2, s); chk("R10 partial byte not loaded", sbit(s, 3), 0);
      byte_x({OWN, 1'b0}, a); chk("R10 address after restart", int'(a), 0);
      byte_x(8'hA5, a); chk("R4 data ack", int'(a), 0);
      hread_buf(d); chk("R5 byte after restart", int'(d), 8'hA5);
      hwrite(2'd2, 8'h00);

      // R10 restart inside address; R3 mismatch then restart
      start_c(); bits_x(8'h12, 3);
      start_c(); byte_x(8'h22, a); chk("R3 mismatch no ack", int'(a), 1);
      byte_x(8'h00, a); chk("R3 ignored data no ack", int'(a), 1);
      peek(2'd2, s); chk("R3 no full after mismatch", sbit(s, 3), 0);
      chk("R3 no irq after mismatch", sbit(s, 2), 0);
      start_c(); byte_x({OWN, 1'b0}, a); chk("R10 match after mismatch", int'(a), 0);
      hwrite(2'd2, 8'h00);

      // R6 hold observed on the line, release by read
      hwrite(2'd0, ctrl_word(1, 0, 0, 0, 1));
      byte_x(8'h3C, a);
      v2 = 8'h81;
      wait_cyc(Q); sda_m = v2[7]; wait_cyc(Q);
      scl_m = 1'b1; wait_cyc(30);
      chk("R6 SCL held low", int'(scl_line), 0);
      peek(2'd2, s); chk("R8 secondary flag", sbit(s, 5), 1);
      chk("R5 irq_o masked", int'(irq_o), 0);
      hread_buf(d); chk("R6 held byte", int'(d), 8'h3C);
      wait_cyc(3); chk("R6 SCL released after read", int'(scl_line), 1);
      wait_cyc(Q); scl_m = 1'b0;
      for (int i = 6; i >= 0; i--) bit_x(v2[i], a);
      bit_x(1'b1, a); chk("R4 ack after hold", int'(a), 0);
      hread_buf(d); chk("R6 byte after hold", int'(d), 8'h81);
      hwrite(2'd2, 8'h00);
      stop_c();
      peek(2'd2, s); chk("R1 busy cleared by stop", sbit(s, 0), 0);
      chk("R1 stop seen", sbit(s, 1), 1);
      chk("R7 stop irq unmasked", sbit(s, 2), 1);
      hwrite(2'd2, 8'h00);

      // R2 read direction, cleared at next start
      start_c(); byte_x({OWN, 1'b1}, a); chk("R2 read address ack", int'(a), 0);
      peek(2'd2, s); chk("R2 direction flag", sbit(s, 4), 1);
      stop_c();
      start_c();
      peek(2'd2, s); chk("R2 direction cleared", sbit(s, 4), 0);
      stop_c();
      hwrite(2'd2, 8'h00);

      // random transfers
      for (int t = 0; t < 30; t++) begin
         bit hold, ien, smask, alt, hit, dir;
         int nb;
         logic [6:0] ad;
         hold = 1'($urandom % 2); ien = 1'($urandom % 2);
         smask = 1'($urandom % 2); alt = 1'($urandom % 2);
         hit = ($urandom % 4) != 0;
         dir = hit && (($urandom % 5) == 0);
         ad = hit ? OWN : (7'($urandom) ^ 7'h01);
         if (!hit && ad == OWN) ad = ~OWN;
         hwrite(2'd0, ctrl_word(hold, 0, ien, smask, alt));
         start_c();
         byte_x({ad, dir}, a);
         chk("R2/R3 address ack", int'(a), exp_ack(1, hit, 0));
         if (hit) begin
            peek(2'd2, s);
            chk("R5 address irq", sbit(s, 2), 1);
            chk("R5 irq_o gating", int'(irq_o), int'(ien));
            chk("R2 direction", sbit(s, 4), int'(dir));
            hwrite(2'd2, 8'h00);
         end
         if (hit && !dir) begin
            nb = 1 + int'($urandom % 4);
            for (int k = 0; k < nb; k++) begin
               bit last;
               logic [7:0] dv;
               last = (k == nb - 1);
               dv = 8'($urandom);
               if (last) hwrite(2'd0, ctrl_word(hold, 1, ien, smask, alt));
               byte_x(dv, a);
               chk("R4 data ack", int'(a), exp_ack(0, 1, last));
               wait_cyc(8);
               chk(hold ? "R6 hold active" : "R11 no hold", int'(scl_low_o), int'(hold));
               peek(2'd2, s);
               chk("R5 full set", sbit(s, 3), 1);
               chk("R8 secondary flag", sbit(s, 5), int'(alt));
               hread_buf(d); chk("R5 buffer", int'(d), int'(dv));
               wait_cyc(2);
               chk("R6 hold released", int'(scl_low_o), 0);
               peek(2'd2, s); chk("R6 full cleared", sbit(s, 3), 0);
               hwrite(2'd2, 8'h00);
            end
         end else if (!hit) begin
            byte_x(8'($urandom), a); chk("R3 ignored byte", int'(a), 1);
            peek(2'd2, s); chk("R3 no flags", int'(s & 8'h2C), 0);
         end
         stop_c();
         peek(2'd2, s);
         chk("R1 stop clears busy", sbit(s, 0), 0);
         chk("R7 stop irq mask", sbit(s, 2), int'(!smask));
         hwrite(2'd2, 8'h00);
         peek(2'd2, s); chk("R9 flags cleared", int'(s & 8'h26), 0);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule